// File: doc/BRIEF.md
# Synthesizer Serial Programming Port

This block is the three-wire programming port of a frequency synthesizer. A host shifts a 19-bit control word in one bit at a time over a serial data line, clocked by a serial clock, most significant bit first. The last bit shifted in is a destination flag. When the load strobe rises, the word is copied into one of two register sets, and the flag picks which one.

The reference set holds the 14-bit reference divide ratio and four single-bit mode controls: prescaler modulus choice, phase-detector polarity, monitor output choice and charge-pump current choice. The divider set holds the 7-bit swallow count and the 11-bit main count. The held fields drive the divider and phase-detector logic downstream.

All three serial lines are treated as asynchronous. They are resynchronised into the system clock before any edge is detected. The block rejects a word whose ratio or main count is below the legal minimum, so the downstream dividers never see a ratio they cannot run.

Top module: `synth_prog_port`

## Requirements
- R1: While reset is low at a clock edge, the outputs take their defaults: ref_ratio = 3, the four mode bits = 0, swal_val = 0 and cnt_val = 3.
- R2: One bit is taken from ser_data on each rising edge of ser_clk. Bits arrive most significant first, so the 19th bit sent becomes word bit 0, which is the destination flag.
- R3: Serial clocking with ser_le low never changes any output.
- R4: A rising ser_le with word bit 0 = 1 loads the reference set. Word bits 14:1 go to ref_ratio (bit 1 is the ratio LSB), bit 15 to presc_sel, bit 16 to phase_inv, bit 17 to mon_sel and bit 18 to cp_hi. swal_val and cnt_val are left unchanged.
- R5: A rising ser_le with word bit 0 = 0 loads the divider set. Word bits 7:1 go to swal_val (bit 1 is the LSB) and bits 18:8 go to cnt_val (bit 8 is the LSB). The reference outputs are left unchanged.
- R6: A reference word whose ratio field is below 3 is discarded whole, mode bits included, and all reference outputs keep their previous values.
- R7: A divider word whose count field is below 3 is discarded whole, swallow field included, and the divider outputs keep their previous values.
- R8: Only the rising edge of ser_le loads. Words shifted in while ser_le stays high change nothing until the next rising edge.
- R9: The extreme legal values load exactly: a ratio of 16383, a swallow count of 127 and a main count of 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe, rising edge transfers the word |
| ref_ratio | output | 14 | Reference divide ratio |
| presc_sel | output | 1 | Prescaler modulus select |
| phase_inv | output | 1 | Phase-detector polarity |
| mon_sel | output | 1 | Monitor output select |
| cp_hi | output | 1 | Charge-pump high-current select |
| swal_val | output | 7 | Swallow count |
| cnt_val | output | 11 | Main counter value |

## Verification
The bench sends ratios and counts of 0, 1, 2 and 3. A design with an off-by-one minimum would either load a value of 2 or refuse a value of 3. It also checks that a rejected reference word leaves the mode bits alone; a design that range-checked only the ratio field would still change them. Words are shifted with the strobe held high, so a level-sensitive load would show up as changed outputs before the next rising edge. Random words of both kinds each check that the other register set stays unchanged, which catches a swapped or ignored destination flag.

// File: rtl/synth_prog_pkg.sv
// Package: shared widths, word layout and register-set types for the
// synthesizer programming port. Assumes a 19-bit word with the flag at bit 0.
package synth_prog_pkg;
    localparam int WORD_W  = 19;
    localparam int REF_W   = 14;
    localparam int SWAL_W  = 7;
    localparam int CNT_W   = 11;
    localparam int REF_MIN = 3;
    localparam int CNT_MIN = 3;

    // Derived field positions inside the shifted word
    localparam int FLAG_BIT = 0;
    localparam int REF_LO   = 1;
    localparam int REF_HI   = REF_LO + REF_W - 1;
    localparam int PRE_BIT  = REF_HI + 1;
    localparam int PHS_BIT  = PRE_BIT + 1;
    localparam int MON_BIT  = PHS_BIT + 1;
    localparam int CP_BIT   = MON_BIT + 1;
    localparam int SWAL_LO  = 1;
    localparam int SWAL_HI  = SWAL_LO + SWAL_W - 1;
    localparam int CNT_LO   = SWAL_HI + 1;
    localparam int CNT_HI   = CNT_LO + CNT_W - 1;

    typedef struct packed {
        logic [REF_W-1:0] ratio;
        logic             presc;
        logic             phase;
        logic             mon;
        logic             cp;
    } ref_set_t;

    typedef struct packed {
        logic [SWAL_W-1:0] swal;
        logic [CNT_W-1:0]  cnt;
    } div_set_t;
endpackage

// File: rtl/in_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes the bundle is sampled together, so all bits share one latency.
module in_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage: sample the raw inputs
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= d;
            end
        end else begin : g_next
            // Later stages: pass along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ser_shift.sv
// Module: serial shift register with bit-clock and strobe edge detection.
// Assumes synchronised inputs; shifts on every bit-clock rise regardless of strobe.
module ser_shift
    import synth_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdata_s,
    input  logic              sle_s,
    output logic [WORD_W-1:0] word,
    output logic              load_pulse
);
    logic sclk_d;
    logic sle_d;

    // Track previous levels and shift one bit in on each bit-clock rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            sle_d  <= 1'b0;
            word   <= '0;
        end else begin
            sclk_d <= sclk_s;
            sle_d  <= sle_s;
            if (sclk_s && !sclk_d)
                word <= {word[WORD_W-2:0], sdata_s};
        end
    end

    // One-cycle pulse on the strobe's rising edge
    assign load_pulse = sle_s && !sle_d;
endmodule

// File: rtl/cfg_latch.sv
// Module: range-checked holding registers for the reference and divider sets.
// Assumes load is a single-cycle pulse; a rejected word leaves its set intact.
module cfg_latch
    import synth_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output ref_set_t          ref_q,
    output div_set_t          div_q
);
    ref_set_t ref_new;
    div_set_t div_new;
    logic     ref_ok;
    logic     div_ok;

    // Decode both candidate sets from the word and check their ranges
    always_comb begin
        ref_new.ratio = word[REF_HI:REF_LO];
        ref_new.presc = word[PRE_BIT];
        ref_new.phase = word[PHS_BIT];
        ref_new.mon   = word[MON_BIT];
        ref_new.cp    = word[CP_BIT];
        div_new.swal  = word[SWAL_HI:SWAL_LO];
        div_new.cnt   = word[CNT_HI:CNT_LO];
        ref_ok = (ref_new.ratio >= REF_W'(REF_MIN));
        div_ok = (div_new.cnt   >= CNT_W'(CNT_MIN));
    end

    // Reference set: reset default, else load on a flagged, legal word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q       <= '0;
            ref_q.ratio <= REF_W'(REF_MIN);
        end else if (load && word[FLAG_BIT] && ref_ok) begin
            ref_q <= ref_new;
        end
    end

    // Divider set: reset default, else load on an unflagged, legal word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q     <= '0;
            div_q.cnt <= CNT_W'(CNT_MIN);
        end else if (load && !word[FLAG_BIT] && div_ok) begin
            div_q <= div_new;
        end
    end
endmodule

// File: rtl/synth_prog_port.sv
// Module: top of the synthesizer programming port. Synchronises the three
// serial lines, shifts the word and routes it to one of two register sets.
// Assumes the serial lines are slow relative to clk (several clk per phase).
module synth_prog_port
    import synth_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    output logic [REF_W-1:0]  ref_ratio,
    output logic              presc_sel,
    output logic              phase_inv,
    output logic              mon_sel,
    output logic              cp_hi,
    output logic [SWAL_W-1:0] swal_val,
    output logic [CNT_W-1:0]  cnt_val
);
    logic [2:0]        lines_s;
    logic [WORD_W-1:0] shift_word;
    logic              load_pulse;
    ref_set_t          ref_q;
    div_set_t          div_q;

    in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_le, ser_data, ser_clk}),
        .q     (lines_s)
    );

    ser_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (lines_s[0]),
        .sdata_s    (lines_s[1]),
        .sle_s      (lines_s[2]),
        .word       (shift_word),
        .load_pulse (load_pulse)
    );

    cfg_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_pulse),
        .word  (shift_word),
        .ref_q (ref_q),
        .div_q (div_q)
    );

    // Drive the flat output fields from the held sets
    always_comb begin
        ref_ratio = ref_q.ratio;
        presc_sel = ref_q.presc;
        phase_inv = ref_q.phase;
        mon_sel   = ref_q.mon;
        cp_hi     = ref_q.cp;
        swal_val  = div_q.swal;
        cnt_val   = div_q.cnt;
    end
endmodule

// File: rtl/synth_prog_port_chk.sv
// Module: property checker for the programming port, bound to the top.
// Assumes load_pulse and shift_word are the top's internal nets.
module synth_prog_port_chk
    import synth_prog_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              load_pulse,
    input logic [WORD_W-1:0] shift_word,
    input logic [REF_W-1:0]  ref_ratio,
    input logic              presc_sel,
    input logic              phase_inv,
    input logic              mon_sel,
    input logic              cp_hi,
    input logic [SWAL_W-1:0] swal_val,
    input logic [CNT_W-1:0]  cnt_val
);
    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pulse |=> $stable({ref_ratio, presc_sel, phase_inv, mon_sel, cp_hi, swal_val, cnt_val})); // R3
    AST_REF_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse && shift_word[FLAG_BIT] && shift_word[REF_HI:REF_LO] >= REF_W'(REF_MIN))
        |=> ref_ratio == $past(shift_word[REF_HI:REF_LO]) && cp_hi == $past(shift_word[CP_BIT])); // R4
    AST_DIV_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse && shift_word[FLAG_BIT]) |=> $stable({swal_val, cnt_val})); // R4
    AST_REF_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse && !shift_word[FLAG_BIT]) |=> $stable({ref_ratio, presc_sel, phase_inv, mon_sel, cp_hi})); // R5
    AST_REF_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ref_ratio >= REF_W'(REF_MIN)); // R6
    AST_CNT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt_val >= CNT_W'(CNT_MIN)); // R7
endmodule

bind synth_prog_port synth_prog_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_pulse (load_pulse),
    .shift_word (shift_word),
    .ref_ratio  (ref_ratio),
    .presc_sel  (presc_sel),
    .phase_inv  (phase_inv),
    .mon_sel    (mon_sel),
    .cp_hi      (cp_hi),
    .swal_val   (swal_val),
    .cnt_val    (cnt_val)
);

// File: tb/synth_prog_port_tb.sv
// Bench: directed corner cases plus seeded random words, checked against a model.
module synth_prog_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_le = 1'b0;
    logic [13:0] ref_ratio;
    logic presc_sel, phase_inv, mon_sel, cp_hi;
    logic [6:0]  swal_val;
    logic [10:0] cnt_val;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Model of the expected register contents
    logic [13:0] e_ratio;
    logic [3:0]  e_mode;   // {cp, mon, phase, presc}
    logic [6:0]  e_swal;
    logic [10:0] e_cnt;

    always #10 clk = ~clk;

    synth_prog_port u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .ref_ratio(ref_ratio), .presc_sel(presc_sel), .phase_inv(phase_inv),
        .mon_sel(mon_sel), .cp_hi(cp_hi), .swal_val(swal_val), .cnt_val(cnt_val)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [18:0] ref_word(input logic [13:0] r, input logic [3:0] m);
        return {m[3], m[2], m[1], m[0], r, 1'b1};
    endfunction

    function automatic logic [18:0] div_word(input logic [6:0] a, input logic [10:0] n);
        return {n, a, 1'b0};
    endfunction

    task automatic shift_word(input logic [18:0] w);
        for (int i = 18; i >= 0; i--) begin
            ser_data = w[i];
            cyc(4);
            ser_clk = 1'b1;
            cyc(4);
            ser_clk = 1'b0;
        end
        cyc(4);
    endtask

    task automatic model_load(input logic [18:0] w);
        if (w[0]) begin
            if (w[14:1] >= 14'd3) begin
                e_ratio = w[14:1];
                e_mode  = w[18:15];
            end
        end else if (w[18:8] >= 11'd3) begin
            e_swal = w[7:1];
            e_cnt  = w[18:8];
        end
    endtask

    task automatic pulse_le();
        ser_le = 1'b1;
        cyc(6);
        ser_le = 1'b0;
        cyc(6);
    endtask

    task automatic send(input logic [18:0] w);
        shift_word(w);
        pulse_le();
        model_load(w);
    endtask

    task automatic check(input string tag);
        logic [35:0] act, exp;
        act = {ref_ratio, cp_hi, mon_sel, phase_inv, presc_sel, swal_val, cnt_val};
        exp = {e_ratio, e_mode, e_swal, e_cnt};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [18:0] w;
        void'($urandom(32'd4242));
        e_ratio = 14'd3; e_mode = 4'd0; e_swal = 7'd0; e_cnt = 11'd3;
        cyc(5);
        check("R1 reset defaults");
        rst_n = 1'b1;
        cyc(3);
        check("R1 after release");

        // R3: shift without a strobe
        shift_word(ref_word(14'd1234, 4'b1010));
        check("R3 shift without strobe");

        // R2/R4: distinct pattern routed to the reference set
        send(ref_word(14'h2A5C, 4'b0110));
        check("R2 R4 reference load");

        // R5: divider load leaves reference alone
        send(div_word(7'd45, 11'd700));
        check("R5 divider load");

        // R6: ratio 0,1,2 rejected with mode bits; 3 accepted
        send(ref_word(14'd2, 4'b1001));
        check("R6 ratio 2 rejected");
        send(ref_word(14'd0, 4'b1111));
        check("R6 ratio 0 rejected");
        send(ref_word(14'd1, 4'b0001));
        check("R6 ratio 1 rejected");
        send(ref_word(14'd3, 4'b0001));
        check("R6 ratio 3 accepted");

        // R7: count 2 rejected with swallow; 3 accepted
        send(div_word(7'd99, 11'd2));
        check("R7 count 2 rejected");
        send(div_word(7'd5, 11'd3));
        check("R7 count 3 accepted");

        // R9: extremes
        send(ref_word(14'd16383, 4'b1111));
        check("R9 ratio max");
        send(div_word(7'd127, 11'd2047));
        check("R9 swallow and count max");

        // R8: strobe held high across a new word
        shift_word(div_word(7'd17, 11'd300));
        ser_le = 1'b1;
        cyc(6);
        model_load(div_word(7'd17, 11'd300));
        check("R8 first rise loads");
        shift_word(div_word(7'd88, 11'd900));
        check("R8 no load while held high");
        ser_le = 1'b0;
        cyc(6);
        check("R8 no load on fall");
        pulse_le();
        model_load(div_word(7'd88, 11'd900));
        check("R8 next rise loads");

        // Random words of both kinds, some with small fields
        for (int k = 0; k < 60; k++) begin
            if ($urandom % 2) begin
                logic [13:0] r;
                r = 14'($urandom);
                if ($urandom % 4 == 0) r = 14'($urandom % 4);
                w = ref_word(r, 4'($urandom));
                send(w);
                check("R4 R6 random reference word");
            end else begin
                logic [10:0] n;
                n = 11'($urandom);
                if ($urandom % 4 == 0) n = 11'($urandom % 4);
                w = div_word(7'($urandom), n);
                send(w);
                check("R5 R7 random divider word");
            end
        end
        finish_run();
    end
endmodule